// File: doc/BRIEF.md
# Serial Bus Clock and Interrupt Control

This block is the clock and interrupt front end of a two-wire display data channel controller. Software reaches it through one 8-bit read/write control word on a simple register bus. The word holds four settings: the acknowledge-enable output, the choice of base clock, the interrupt enable, and a 4-bit divide value. It also shows the interrupt pending flag. The flag is set by event strobes from the rest of the controller: address hit, arbitration loss, byte complete, and entry into the first display data mode. Software clears the flag by writing it with zero.

The serial clock is built in one oscillator clock domain from enable pulses, with no gated clock. A predivider makes a base tick every 10 or every 256 oscillator cycles. A half-period counter then toggles the clock after N+1 base ticks. The generator is a three-state machine:

- **PH_LOW**: the clock is driven low. This state moves to PH_HIGH at the half-period boundary.
- **PH_HIGH**: the clock is released high. This state moves to PH_STRETCH when the sensed line is low, or to PH_LOW at the boundary.
- **PH_STRETCH**: the clock is still released, but a slave holds the line low, so counting is frozen. This state moves back to PH_HIGH when the line rises. If that same cycle is a boundary, it moves straight to PH_LOW.

New divide and source settings are taken up only at a half-period boundary.

Top module: `ddc_clkctl`

## Requirements
- R1: After reset, rdata reads 0x00, ack_en and irq are 0, and scl_out is 1 (the machine is in PH_HIGH).
- R2: ack_en equals bit 7 of the last value written.
- R3: Bits 7, 6, 5 and 3..0 read back exactly as last written.
- R4: irq is 1 exactly when bit 5 (interrupt enable) and the visible pending flag (bit 4) are both 1.
- R5: Any one of the four event strobes sets the pending flag (bit 4) on the next cycle, provided stat_en is 1.
- R6: Writing 0 to bit 4 clears the pending flag. Writing 1 to bit 4 leaves it as it was.
- R7: If an event strobe and a clearing write occur in the same cycle, the flag ends up set.
- R8: While stat_en is 0, bit 4 reads 0, irq is 0, and events are not recorded.
- R9: With bit 6 at 0, each half period of scl_out lasts (N+1)*10 clk cycles. With bit 6 at 1, it lasts (N+1)*256 cycles. N is bits 3..0.
- R10: While scl_out is 1 and scl_in is 0, counting pauses and scl_out stays 1. The high half period grows by exactly the number of held cycles.
- R11: A write to bits 6 or 3..0 does not alter the half period in progress. It applies from the next half period onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wdata | input | 8 | Control word write data |
| rdata | output | 8 | Control word read data |
| stat_en | input | 1 | Status enable; 0 hides and blocks the pending flag |
| ev_addr_hit | input | 1 | Slave address matched |
| ev_arb_lost | input | 1 | Arbitration lost as master |
| ev_xfer_done | input | 1 | One byte sent or received |
| ev_mode1_entry | input | 1 | First display data mode entered after prebuffer use |
| scl_in | input | 1 | Sensed serial clock line level |
| scl_out | output | 1 | Serial clock drive (1 = released high) |
| ack_en | output | 1 | Acknowledge generation enable |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are the ones that depend on exact timing against the clock generator's internal phase. One is a divide value rewritten in the middle of a half period. The other is a slave hold that begins partway through a high phase. The stimulus first synchronises to an observed scl_out edge. It then waits a known number of cycles, and only then applies the write or pulls scl_in low for a counted number of cycles. The measured edge-to-edge distances can therefore be predicted exactly. The flag collision case needs a clearing write and an event strobe in the same cycle. It is driven directly, and it also comes up during the random register traffic.

// File: rtl/ddc_clkctl_pkg.sv
package ddc_clkctl_pkg;
    localparam int CTL_W    = 8;
    localparam int PS_W     = 4;
    localparam int ACK_BIT  = 7;
    localparam int SRC_BIT  = 6;
    localparam int IEN_BIT  = 5;
    localparam int PEND_BIT = 4;
    localparam int NUM_EV   = 4;

    typedef enum logic [1:0] {
        PH_LOW     = 2'd0,
        PH_HIGH    = 2'd1,
        PH_STRETCH = 2'd2
    } phase_t;
endpackage

// File: rtl/ddc_prediv.sv
module ddc_prediv #(
    parameter int DIV_FAST = 10,
    parameter int DIV_SLOW = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_slow,
    input  logic run,
    output logic tick
);
    localparam int MAXD = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
    localparam int CW   = (MAXD > 2) ? $clog2(MAXD) : 1;
    localparam logic [CW-1:0] LIM_FAST = CW'(DIV_FAST - 1);
    localparam logic [CW-1:0] LIM_SLOW = CW'(DIV_SLOW - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    always_comb begin
        lim  = sel_slow ? LIM_SLOW : LIM_FAST;
        tick = run && (cnt_q >= lim);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ddc_sclgen.sv
module ddc_sclgen
    import ddc_clkctl_pkg::*;
#(
    parameter int PW = PS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [PW-1:0] ps_req,
    input  logic          src_req,
    input  logic          scl_in,
    output logic          scl_out,
    output logic          run,
    output logic          src_act
);
    phase_t        state_q, state_d;
    logic [PW-1:0] hcnt_q, ps_act_q;
    logic          src_q;
    logic          boundary;

    assign boundary = tick && (hcnt_q == ps_act_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= PH_HIGH;
            hcnt_q   <= '0;
            ps_act_q <= '0;
            src_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (boundary) begin
                hcnt_q   <= '0;
                ps_act_q <= ps_req;
                src_q    <= src_req;
            end else if (tick) begin
                hcnt_q <= hcnt_q + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_LOW:     if (boundary) state_d = PH_HIGH;
            PH_HIGH: begin
                if (!scl_in)       state_d = PH_STRETCH;
                else if (boundary) state_d = PH_LOW;
            end
            PH_STRETCH: if (scl_in) state_d = boundary ? PH_LOW : PH_HIGH;
            default:    state_d = PH_HIGH;
        endcase
    end

    // outputs
    always_comb begin
        scl_out = (state_q != PH_LOW);
        run     = !scl_out || scl_in;
        src_act = src_q;
    end
endmodule

// File: rtl/ddc_ctlreg.sv
module ddc_ctlreg
    import ddc_clkctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTL_W-1:0]  wdata,
    input  logic              stat_en,
    input  logic [NUM_EV-1:0] ev,
    output logic [CTL_W-1:0]  rdata,
    output logic              irq,
    output logic              ack_en,
    output logic              src_sel,
    output logic [PS_W-1:0]   ps_val
);
    logic [CTL_W-1:0] cfg_q;
    logic             flag_q, flag_d, clr_wr, vis_flag;

    always_comb begin
        clr_wr   = wr_en && !wdata[PEND_BIT];
        flag_d   = stat_en && ((|ev) || (flag_q && !clr_wr));
        vis_flag = flag_q && stat_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (wr_en) begin
                cfg_q           <= wdata;
                cfg_q[PEND_BIT] <= 1'b0;
            end
            flag_q <= flag_d;
        end
    end

    always_comb begin
        rdata           = cfg_q;
        rdata[PEND_BIT] = vis_flag;
        irq             = cfg_q[IEN_BIT] && vis_flag;
        ack_en          = cfg_q[ACK_BIT];
        src_sel         = cfg_q[SRC_BIT];
        ps_val          = cfg_q[PS_W-1:0];
    end
endmodule

// File: rtl/ddc_clkctl.sv
module ddc_clkctl
    import ddc_clkctl_pkg::*;
#(
    parameter int DIV_FAST = 10,
    parameter int DIV_SLOW = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       stat_en,
    input  logic       ev_addr_hit,
    input  logic       ev_arb_lost,
    input  logic       ev_xfer_done,
    input  logic       ev_mode1_entry,
    input  logic       scl_in,
    output logic       scl_out,
    output logic       ack_en,
    output logic       irq
);
    logic [NUM_EV-1:0] ev;
    logic              src_sel, src_act, run, tick;
    logic [PS_W-1:0]   ps_val;

    assign ev = {ev_mode1_entry, ev_xfer_done, ev_arb_lost, ev_addr_hit};

    ddc_ctlreg u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
        .stat_en(stat_en), .ev(ev), .rdata(rdata), .irq(irq),
        .ack_en(ack_en), .src_sel(src_sel), .ps_val(ps_val)
    );

    ddc_prediv #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_pre (
        .clk(clk), .rst_n(rst_n), .sel_slow(src_act), .run(run), .tick(tick)
    );

    ddc_sclgen #(.PW(PS_W)) u_gen (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ps_req(ps_val),
        .src_req(src_sel), .scl_in(scl_in), .scl_out(scl_out),
        .run(run), .src_act(src_act)
    );
endmodule

// File: rtl/ddc_clkctl_chk.sv
module ddc_clkctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       stat_en,
    input logic       ev_addr_hit,
    input logic       ev_arb_lost,
    input logic       ev_xfer_done,
    input logic       ev_mode1_entry,
    input logic       scl_in,
    input logic       scl_out,
    input logic       ack_en,
    input logic       irq
);
    logic any_ev;
    assign any_ev = ev_addr_hit || ev_arb_lost || ev_xfer_done || ev_mode1_entry;

    assert_ack_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ack_en == $past(wdata[7])));

    assert_irq_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rdata[5] && rdata[4]));

    assert_ev_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_en && any_ev) |=> (!stat_en || rdata[4]));

    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wdata[4] && !any_ev) |=> !rdata[4]);

    assert_write_one_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[4] && !any_ev && stat_en) |=>
            (!stat_en || (rdata[4] == $past(rdata[4]))));

    assert_stat_hides_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_en |-> (!rdata[4] && !irq));

    assert_stretch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_out && !scl_in) |=> scl_out);
endmodule

bind ddc_clkctl ddc_clkctl_chk u_chk (.*);

// File: tb/ddc_clkctl_tb.sv
module ddc_clkctl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       stat_en = 1'b1;
    logic       ev_addr_hit = 1'b0, ev_arb_lost = 1'b0;
    logic       ev_xfer_done = 1'b0, ev_mode1_entry = 1'b0;
    logic       slave_hold = 1'b0;
    logic       scl_in, scl_out, ack_en, irq;
    int         checks = 0, errors = 0;
    longint     cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign scl_in = scl_out && !slave_hold;

    ddc_clkctl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .stat_en(stat_en), .ev_addr_hit(ev_addr_hit), .ev_arb_lost(ev_arb_lost),
        .ev_xfer_done(ev_xfer_done), .ev_mode1_entry(ev_mode1_entry),
        .scl_in(scl_in), .scl_out(scl_out), .ack_en(ack_en), .irq(irq)
    );

    // bench model of the register
    logic [7:0] m_cfg = '0;
    logic       m_flag = 1'b0;

    function automatic logic next_flag(logic f, logic st, logic anyev, logic wr, logic b4);
        return st && (anyev || (f && !(wr && !b4)));
    endfunction

    function automatic longint half_len(int n, logic slow);
        return longint'(n + 1) * (slow ? 256 : 10);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one cycle of register traffic, then compare against the model
    task automatic step(input logic wr, input logic [7:0] d, input logic st,
                        input logic [3:0] e, input string req);
        logic [7:0] exp_rd;
        @(negedge clk);
        wr_en = wr; wdata = d; stat_en = st;
        {ev_mode1_entry, ev_xfer_done, ev_arb_lost, ev_addr_hit} = e;
        m_flag = next_flag(m_flag, st, |e, wr, d[4]);
        if (wr) m_cfg = d & 8'hEF;
        @(negedge clk);
        wr_en = 1'b0; ev_addr_hit = 0; ev_arb_lost = 0; ev_xfer_done = 0; ev_mode1_entry = 0;
        exp_rd = m_cfg | {3'b0, m_flag && st, 4'b0};
        chk(rdata == exp_rd, {req, " rdata"}, rdata, exp_rd);
        chk(irq == (m_cfg[5] && m_flag && st), {req, " irq R4"}, irq, m_cfg[5] && m_flag && st);
        chk(ack_en == m_cfg[7], {req, " ack R2"}, ack_en, m_cfg[7]);
    endtask

    task automatic next_edge(output longint t);
        logic v;
        v = scl_out;
        do begin @(posedge clk); #1; end while (scl_out == v);
        t = cyc;
    endtask

    task automatic set_clk(input int n, input logic slow);
        step(1'b1, {1'b0, slow, 1'b0, 1'b1, 4'(n)}, 1'b1, 4'b0, "cfg R3");
    endtask

    task automatic period_check(input int n, input logic slow);
        longint ta, t0, t1;
        set_clk(n, slow);
        next_edge(ta); next_edge(t0); next_edge(t1);
        chk((t1 - t0) == half_len(n, slow), "R9 half period", t1 - t0, half_len(n, slow));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        longint t0, t1, t2;
        void'($urandom(32'h5EED_0C1D));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rdata == 8'h00, "R1 rdata", rdata, 0);
        chk(!ack_en && !irq, "R1 ack/irq", {ack_en, irq}, 0);
        chk(scl_out == 1'b1, "R1 scl_out", scl_out, 1);

        // R3 readback of all writable bits, bit 4 stays 0
        step(1'b1, 8'hFF, 1'b1, 4'b0, "R3 all ones");
        step(1'b1, 8'h00, 1'b1, 4'b0, "R3 zeros");
        // R5 each event source, cleared in between (R6)
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 8'h00, 1'b1, 4'(1 << i), "R5 event");
            chk(rdata[4], "R5 flag set", rdata[4], 1);
            step(1'b1, 8'h20, 1'b1, 4'b0, "R6 clear");
        end
        // R6 write one keeps flag; R4 irq with enable
        step(1'b0, 8'h00, 1'b1, 4'b0010, "R5 arb");
        step(1'b1, 8'h30, 1'b1, 4'b0, "R6 write one");
        chk(rdata[4] && irq, "R6 keep / R4 irq", {rdata[4], irq}, 3);
        // R7 collision: clear and event together
        step(1'b1, 8'h20, 1'b1, 4'b0100, "R7 collide");
        chk(rdata[4], "R7 set wins", rdata[4], 1);
        // R8 stat_en low hides flag and blocks events
        step(1'b0, 8'h00, 1'b0, 4'b1111, "R8 hidden");
        chk(!rdata[4] && !irq, "R8 hidden", {rdata[4], irq}, 0);
        step(1'b0, 8'h00, 1'b1, 4'b0, "R8 not recorded");
        chk(!rdata[4], "R8 not recorded", rdata[4], 0);

        // random register traffic against the model
        for (int i = 0; i < 120; i++) begin
            logic [3:0] e;
            e = 4'b0;
            for (int k = 0; k < 4; k++) e[k] = ($urandom_range(0, 5) == 0);
            step($urandom_range(0, 2) == 0, 8'($urandom), $urandom_range(0, 6) != 0, e, "R3/R5/R6 random");
        end

        // R9 clock divide, both sources, corners and random values
        period_check(0, 1'b0);
        period_check(15, 1'b0);
        period_check(0, 1'b1);
        period_check(2, 1'b1);
        for (int i = 0; i < 4; i++) period_check($urandom_range(0, 15), 1'b0);

        // R11 mid-period rewrite does not cut the current half
        set_clk(3, 1'b0);
        next_edge(t0); next_edge(t0);
        repeat (5) @(negedge clk);
        set_clk(7, 1'b0);
        next_edge(t1); next_edge(t2);
        chk((t1 - t0) == 40, "R11 current half", t1 - t0, 40);
        chk((t2 - t1) == 80, "R11 next half", t2 - t1, 80);

        // R10 stretch during high phase
        set_clk(1, 1'b0);
        next_edge(t0); next_edge(t0);
        if (!scl_out) next_edge(t0);
        @(negedge clk);
        repeat (4) @(negedge clk);
        slave_hold = 1'b1;
        repeat (30) @(negedge clk);
        chk(scl_out == 1'b1, "R10 held high", scl_out, 1);
        slave_hold = 1'b0;
        next_edge(t1);
        chk((t1 - t0) == 50, "R10 stretched half", t1 - t0, 50);
        next_edge(t2);
        chk((t2 - t1) == 20, "R10 low half after", t2 - t1, 20);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule